// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a synchronous slave for a two-wire open-drain serial bus, fronting a small bank of 8-bit control registers. Both bus lines are brought into the system clock domain through a two-flop synchronizer and a short persistence filter. Bus conditions and clock edges are then found from the filtered samples, so the system clock must run at least sixteen times faster than the serial clock. The block answers a single fixed 7-bit device address. It never drives the data line high. Its only output towards the line is an active-low enable that pulls the line to ground.

A write frame carries the device address with the direction bit clear, then one byte that loads the register pointer, then any number of data bytes. Each data byte lands at the pointer, and the pointer then advances. A read frame carries the device address with the direction bit set. It has no pointer byte: the slave streams register contents from the stored pointer for as long as the master acknowledges. The master ends the frame with a not-acknowledge and a STOP. The whole bank is visible at all times on a flat parallel output.

The controller walks these states. S_IDLE waits for a START. S_ADDR shifts in the address byte. S_AACK holds the acknowledge. S_REG takes the pointer byte and S_RACK acknowledges it. S_WDATA takes a data byte and S_WACK acknowledges it. S_RDATA sends a byte and S_TACK listens for the master's acknowledge. S_IGNORE sits out a frame addressed elsewhere or ended by a not-acknowledge.

The transitions are as follows. Any START goes to S_ADDR, and any STOP goes to S_IDLE. From S_ADDR, the falling edge after the eighth bit goes to S_AACK on an address match and to S_IGNORE otherwise. S_AACK goes to S_RDATA or S_REG, depending on the direction bit. S_REG goes to S_RACK. S_RACK goes to S_WDATA. S_WDATA and S_WACK alternate. S_RDATA goes to S_TACK. S_TACK returns to S_RDATA on an acknowledge and goes to S_IGNORE on a not-acknowledge.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the data-line enable `sda_oe_n` is 1 (line released) and every register reads 0.
- R2: A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high. A STOP in any phase returns the block to idle with the data line released.
- R3: The first byte after a START is taken MSB first. Its upper seven bits are compared with parameter DEV_ADDR (default 7'h4C), and its bit 0 is the direction (0 = write, 1 = read). On a match, the slave pulls the data line low through the whole ninth clock.
- R4: On an address mismatch the slave leaves the data line released in the ninth clock. It then ignores all traffic, driving nothing and writing nothing, until the next START or STOP.
- R5: In a write frame the byte after the address loads the pointer from its low log2(NREGS) bits. Each following byte is stored at the pointer. Every byte of the frame is acknowledged.
- R6: The pointer advances by one after each data byte written or read, wrapping from NREGS-1 to 0.
- R7: In a read frame the slave sends the register at the pointer, MSB first. It sends further bytes while the master acknowledges (data low in the ninth clock). After a not-acknowledge it releases the line for the rest of the frame.
- R8: A REPEATED START restarts address matching without a STOP and keeps the pointer, so a pointer-only write followed by a repeated-start read returns data from that pointer.
- R9: A STOP in the middle of a byte aborts it: no partial data byte is written.
- R10: The slave changes `sda_oe_n` only while the clock line is low.
- R11: A clock-line pulse shorter than FILT (default 3) system clocks is filtered out and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_n | output | 1 | Active-low enable that pulls the data line to ground |
| regs_o | output | NREGS*8 | All registers, register i at bits [8i+7:8i] |

## Verification
Committing a data byte and advancing the pointer happen on the same filtered clock fall, so the next byte of a burst has to land one register further on. This is provoked by a two-byte burst that starts at the last register, which makes the commit and the wrap coincide. The result is judged on the parallel output: the first byte must sit in the top register and the second in register 0. A second coincidence is a glitch on the clock line that falls inside a byte being shifted in. It is judged by the stored value still matching the byte the master sent.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_REG,
        S_RACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_TACK,
        S_IGNORE
    } slv_state_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            run_q   <= '0;
            level_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == level_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT - 1)) begin
                level_q <= sync_q[1];
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign dout = level_q;

    // R11: the filtered level only moves to the value the synchronizer held
    p_filter_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> (level_q == $past(sync_q[1])));

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NREGS = 8,
    parameter int PW    = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PW-1:0]      waddr,
    input  logic [7:0]         wdata,
    input  logic [PW-1:0]      raddr,
    output logic [7:0]         rdata,
    output logic [NREGS*8-1:0] flat
);
    logic [7:0] mem [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (we && (waddr == PW'(i))) begin
                mem[i] <= wdata;
            end
        end
        assign flat[i*8 +: 8] = mem[i];
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter int         NREGS    = 8,
    parameter int         PW       = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic [7:0]    rdata,
    output logic          we,
    output logic [PW-1:0] ptr,
    output logic [7:0]    wdata,
    output logic          pull
);
    slv_state_t state, state_n;

    logic       scl_d, sda_d;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic       rw, mack;
    logic       rise, fall, start_c, stop_c, byte_end, addr_hit;
    logic [2:0] bit_sel;

    assign rise     = scl_f & ~scl_d;
    assign fall     = ~scl_f & scl_d;
    assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
    assign byte_end = fall && (cnt == 4'd8);
    assign addr_hit = (shreg[7:1] == DEV_ADDR);
    assign bit_sel  = 3'(4'd7 - cnt);

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(NREGS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        state_n = state;
        if (start_c) begin
            state_n = S_ADDR;
        end else if (stop_c) begin
            state_n = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE, S_IGNORE: state_n = state;
                S_ADDR:  if (byte_end) state_n = addr_hit ? S_AACK : S_IGNORE;
                S_AACK:  if (fall) state_n = rw ? S_RDATA : S_REG;
                S_REG:   if (byte_end) state_n = S_RACK;
                S_RACK:  if (fall) state_n = S_WDATA;
                S_WDATA: if (byte_end) state_n = S_WACK;
                S_WACK:  if (fall) state_n = S_WDATA;
                S_RDATA: if (byte_end) state_n = S_TACK;
                S_TACK:  if (fall) state_n = mack ? S_RDATA : S_IGNORE;
                default: state_n = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    assign we    = (state == S_WDATA) && byte_end && !start_c && !stop_c;
    assign wdata = shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
            cnt   <= '0;
            shreg <= '0;
            tx    <= '0;
            rw    <= 1'b0;
            mack  <= 1'b0;
            ptr   <= '0;
            pull  <= 1'b0;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
            if (start_c || stop_c) begin
                cnt  <= '0;
                pull <= 1'b0;
            end else begin
                unique case (state)
                    S_ADDR, S_REG, S_WDATA: begin
                        if (rise) begin
                            shreg <= {shreg[6:0], sda_f};
                            cnt   <= cnt + 1'b1;
                        end
                        if (byte_end) begin
                            pull <= (state != S_ADDR) || addr_hit;
                            if (state == S_ADDR) rw <= shreg[0];
                            if (state == S_REG) ptr <= shreg[PW-1:0];
                            if (state == S_WDATA) ptr <= next_ptr(ptr);
                        end
                    end
                    S_AACK, S_RACK, S_WACK: begin
                        if (fall) begin
                            cnt  <= '0;
                            pull <= 1'b0;
                            if (state == S_AACK && rw) begin
                                tx   <= rdata;
                                pull <= ~rdata[7];
                            end
                        end
                    end
                    S_RDATA: begin
                        if (rise) cnt <= cnt + 1'b1;
                        if (byte_end) begin
                            pull <= 1'b0;
                            ptr  <= next_ptr(ptr);
                        end else if (fall) begin
                            pull <= ~tx[bit_sel];
                        end
                    end
                    S_TACK: begin
                        if (rise) mack <= ~sda_f;
                        if (fall) begin
                            cnt <= '0;
                            if (mack) begin
                                tx   <= rdata;
                                pull <= ~rdata[7];
                            end
                        end
                    end
                    default: pull <= 1'b0;
                endcase
            end
        end
    end

    // R10: the line enable moves only while the filtered clock is low
    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull) |-> !scl_f);

    // R4: nothing is driven while a foreign or finished frame is ignored
    p_ignore_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> !pull);

    // R2: a stop always lands in idle
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (state == S_IDLE));

    // R8: any start, repeated or not, restarts address matching
    p_start_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (state == S_ADDR));

    // R7: the line is released while the master acknowledges a read byte
    p_master_ack_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TACK) |-> !pull);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter int         NREGS    = 8,
    parameter int         FILT     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_n,
    output logic [NREGS*8-1:0] regs_o
);
    localparam int PW = $clog2(NREGS);

    logic [1:0]    line_raw, line_f;
    logic          we, pull;
    logic [PW-1:0] ptr;
    logic [7:0]    wdata, rdata;

    assign line_raw = {scl_i, sda_i};

    for (genvar i = 0; i < 2; i++) begin : g_line
        i2c_line_filter #(.FILT(FILT)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[i]),
            .dout (line_f[i])
        );
    end

    i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS), .PW(PW)) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(line_f[1]),
        .sda_f(line_f[0]),
        .rdata(rdata),
        .we   (we),
        .ptr  (ptr),
        .wdata(wdata),
        .pull (pull)
    );

    i2c_reg_bank #(.NREGS(NREGS), .PW(PW)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .waddr(ptr),
        .wdata(wdata),
        .raddr(ptr),
        .rdata(rdata),
        .flat (regs_o)
    );

    assign sda_oe_n = ~pull;

endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
    localparam int NREGS = 8;
    localparam int Q     = 40;
    localparam logic [6:0] DEV = 7'h4C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe_n;
    logic sda_line;
    logic [NREGS*8-1:0] regs_o;

    int n_chk = 0;
    int n_fail = 0;
    int drive_cnt = 0;
    int hi_change = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & sda_oe_n;

    i2c_reg_slave #(.DEV_ADDR(DEV), .NREGS(NREGS), .FILT(3)) i_i2c_reg_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe_n(sda_oe_n),
        .regs_o  (regs_o)
    );

    logic oe_prev = 1'b1;
    always @(negedge clk) begin
        if (!sda_oe_n) drive_cnt++;
        if (rst_n && (sda_oe_n != oe_prev) && scl_m) hi_change++;
        oe_prev <= sda_oe_n;
    end

    function automatic logic [7:0] rg(input int i);
        return regs_o[i*8 +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(ack);
    endtask

    task automatic m_rbyte(input logic nack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            d[i] = b;
        end
        m_wbit(nack);
    endtask

    task automatic t_reset();
        chk(sda_oe_n == 1'b1, "R1 line released", int'(sda_oe_n), 1);
        chk(regs_o == '0, "R1 registers zero", int'(regs_o[31:0]), 0);
    endtask

    task automatic t_write();
        logic a;
        m_start();
        m_wbyte({DEV, 1'b0}, a); chk(a == 1'b0, "R3 address ack", int'(a), 0);
        m_wbyte(8'h02, a);       chk(a == 1'b0, "R5 pointer ack", int'(a), 0);
        m_wbyte(8'hA5, a);       chk(a == 1'b0, "R5 data ack", int'(a), 0);
        m_wbyte(8'h3C, a);       chk(a == 1'b0, "R5 data ack 2", int'(a), 0);
        m_stop();
        chk(rg(2) == 8'hA5, "R5 reg2", int'(rg(2)), 'hA5);
        chk(rg(3) == 8'h3C, "R6 reg3 after increment", int'(rg(3)), 'h3C);
        chk(sda_oe_n == 1'b1, "R2 released after stop", int'(sda_oe_n), 1);
    endtask

    task automatic t_wrap_write();
        logic a;
        m_start();
        m_wbyte({DEV, 1'b0}, a);
        m_wbyte(8'h07, a);
        m_wbyte(8'h11, a);
        m_wbyte(8'h22, a);
        m_stop();
        chk(rg(7) == 8'h11, "R6 top register", int'(rg(7)), 'h11);
        chk(rg(0) == 8'h22, "R6 wrap to reg0", int'(rg(0)), 'h22);
    endtask

    task automatic t_rstart_read();
        logic a;
        logic [7:0] d;
        m_start();
        m_wbyte({DEV, 1'b0}, a);
        m_wbyte(8'h02, a);
        m_start();
        m_wbyte({DEV, 1'b1}, a); chk(a == 1'b0, "R8 read address ack after repeated start", int'(a), 0);
        m_rbyte(1'b0, d); chk(d == 8'hA5, "R7 read byte 0", int'(d), 'hA5);
        m_rbyte(1'b0, d); chk(d == 8'h3C, "R7 read byte 1", int'(d), 'h3C);
        m_rbyte(1'b1, d); chk(d == 8'h00, "R7 read byte 2", int'(d), 0);
        drive_cnt = 0;
        wq(2 * Q);
        chk(drive_cnt == 0, "R7 released after nack", drive_cnt, 0);
        m_stop();
    endtask

    task automatic t_read_wrap();
        logic a;
        logic [7:0] d;
        m_start();
        m_wbyte({DEV, 1'b0}, a);
        m_wbyte(8'h07, a);
        m_stop();
        m_start();
        m_wbyte({DEV, 1'b1}, a);
        m_rbyte(1'b0, d); chk(d == 8'h11, "R6 read at stored pointer", int'(d), 'h11);
        m_rbyte(1'b1, d); chk(d == 8'h22, "R6 read wraps to reg0", int'(d), 'h22);
        m_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        drive_cnt = 0;
        m_start();
        m_wbyte({7'h23, 1'b0}, a); chk(a == 1'b1, "R4 mismatch nack", int'(a), 1);
        m_wbyte(8'h01, a);
        m_wbyte(8'h5A, a);
        chk(drive_cnt == 0, "R4 no drive while ignored", drive_cnt, 0);
        chk(rg(1) == 8'h00, "R4 reg1 untouched", int'(rg(1)), 0);
        m_start();
        m_wbyte({DEV, 1'b0}, a); chk(a == 1'b0, "R4 new start reopens matching", int'(a), 0);
        m_stop();
    endtask

    task automatic t_abort();
        logic a;
        m_start();
        m_wbyte({DEV, 1'b0}, a);
        m_wbyte(8'h01, a);
        for (int i = 0; i < 4; i++) m_wbit(1'b1);
        m_stop();
        chk(rg(1) == 8'h00, "R9 partial byte not written", int'(rg(1)), 0);
        chk(sda_oe_n == 1'b1, "R2 stop mid byte releases", int'(sda_oe_n), 1);
    endtask

    task automatic t_glitch();
        logic a;
        logic [7:0] d = 8'h81;
        m_start();
        m_wbyte({DEV, 1'b0}, a);
        m_wbyte(8'h04, a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = d[i]; wq(Q / 2);
            if (i == 4) begin
                scl_m = 1'b1; wq(1); scl_m = 1'b0;
                wq(Q / 2 - 1);
            end else begin
                wq(Q / 2);
            end
            scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
        end
        m_rbit(a); chk(a == 1'b0, "R11 byte acked in place", int'(a), 0);
        m_stop();
        chk(rg(4) == 8'h81, "R11 glitch ignored", int'(rg(4)), 'h81);
    endtask

    initial begin
        wq(10);
        rst_n = 1'b1;
        wq(10);
        t_reset();
        t_write();
        t_wrap_write();
        t_rstart_read();
        t_read_wrap();
        t_mismatch();
        t_abort();
        t_glitch();
        chk(hi_change == 0, "R10 enable moved with clock high", hi_change, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule